// File: doc/BRIEF.md
# Task Switch Control Sequencer

This block is a finite-state controller that walks a processor through the closing phases of a hardware task switch. A one-cycle start pulse arrives with a cause code. The sequencer then works through up to four steps in a fixed order. Each step is carried out by an outside agent, and the sequencer exchanges a request and a response with that agent for every step. The steps are: mark the incoming task's descriptor busy, load the task register, restore the saved register state, and load and qualify the segment descriptors.

The steps before this block (the checks and the save of the outgoing task) are outside it. So are memory access and descriptor decoding. They appear here only as shared done and error responses. The sequencer decides what an error means from the step it arrives in. An error before the descriptor step undoes the switch. An error during the state restore leaves the machine possibly corrupt and reports the fault to the old task. An error once the switch is committed still finishes the switch and reports the fault to the new task. The privilege level of the new task is captured from the code selector that the state restore delivers.

Top module: `tswitch_seq`

## Requirements
- R1: After reset, busy_o, commit_o, begin_o, rollback_o, corrupt_o and all four step requests are 0, fault_o is 00 and new_cpl_o is 00.
- R2: A start accepted with cause_i = 4 (return from interrupt) skips the busy-mark step, so the first request is treg_req_o. Every other cause value gets set_busy_req_o as the first request: 0 call, 1 jump, 2 interrupt, 3 exception, and also the unused codes 5 to 7.
- R3: The steps run in the order busy-mark, task register, state restore, descriptors. Each request is high for exactly the first cycle of its step. The next request rises only in the cycle after done_i is sampled high. A response is accepted in any cycle of a step, including its request cycle. err_i wins over done_i.
- R4: err_i during the busy-mark or task-register step gives a one-cycle rollback_o pulse in the next cycle and sets fault_o to 01. No further request follows, and the block returns to idle.
- R5: err_i during the state-restore step gives a one-cycle corrupt_o pulse in the next cycle and sets fault_o to 10. No descriptor request and no begin_o follow.
- R6: commit_o is high in every cycle of the descriptor step and in no other cycle.
- R7: done_i in the descriptor step gives a one-cycle begin_o pulse in the next cycle with fault_o = 00. err_i in the descriptor step ends the switch at once with the same begin_o pulse, fault_o = 11, and no further request. At most one of begin_o, rollback_o and corrupt_o is high in any cycle.
- R8: new_cpl_o takes the value of new_cs_rpl_i sampled with done_i in the state-restore step. It does not depend on the outgoing task.
- R9: busy_o is high from the cycle after an accepted start up to the last cycle of the switch. It is low in the cycle of the outcome pulse. A start_i pulse while busy_o is high is ignored.
- R10: fault_o keeps the outcome code of the last switch while idle. It clears to 00 when the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle start pulse |
| cause_i | input | 3 | Cause code sampled with start_i |
| done_i | input | 1 | Step completed (pulse) |
| err_i | input | 1 | Step reported an unrecoverable error (pulse) |
| new_cs_rpl_i | input | 2 | Privilege field of the restored code selector, valid with done_i in the state-restore step |
| busy_o | output | 1 | Switch in progress |
| set_busy_req_o | output | 1 | Request: mark incoming descriptor busy |
| treg_req_o | output | 1 | Request: load task register |
| state_req_o | output | 1 | Request: restore saved register state |
| desc_req_o | output | 1 | Request: load and qualify segment descriptors |
| commit_o | output | 1 | Switch is past its commit point |
| begin_o | output | 1 | Pulse: new task may start executing |
| rollback_o | output | 1 | Pulse: restore prior architectural state |
| corrupt_o | output | 1 | Pulse: state may be corrupt, fault goes to old task |
| fault_o | output | 2 | 00 none, 01 pre-commit abort, 10 state-restore fault, 11 post-commit fault |
| new_cpl_o | output | 2 | Privilege level of the new task |

## Verification
The assertions check on every cycle the properties that need no scenario. Requests are mutually exclusive single-cycle pulses. Outcome pulses are exclusive and each carries its matching fault code. commit_o is bounded to the descriptor step, and busy_o and fault_o behave correctly around an accepted start. Only the bench's scenarios can show the rest. These are the step order chosen by each cause code, the skipped busy-mark for a return, the mapping from the step that fails to the outcome, the captured privilege level, and that a start arriving mid-switch leaves the sequence untouched.

// File: rtl/tsw_pkg.sv
// Shared types and constants for the task switch sequencer.
package tsw_pkg;
    localparam int CAUSE_W   = 3;
    localparam int RPL_W     = 2;
    localparam int NUM_STEPS = 4;
    localparam int PHASE_W   = $clog2(NUM_STEPS + 1);

    // Cause value that skips the busy-mark step (return from interrupt).
    localparam logic [CAUSE_W-1:0] CAUSE_IRET = 3'd4;

    // Outcome code reported on fault_o.
    typedef enum logic [1:0] {
        FLT_NONE    = 2'b00,
        FLT_ABORT   = 2'b01,
        FLT_CORRUPT = 2'b10,
        FLT_POST    = 2'b11
    } fault_e;

    // Sequencer phase; a step k (0-based) is encoded as k+1.
    typedef enum logic [PHASE_W-1:0] {
        PH_IDLE  = 3'd0,
        PH_BUSYF = 3'd1,
        PH_TREG  = 3'd2,
        PH_STATE = 3'd3,
        PH_DESC  = 3'd4
    } phase_e;
endpackage

// File: rtl/tsw_step_fsm.sv
// Step sequencer: accepts a start while idle, walks the steps in order,
// issues a one-cycle request on entering each step and waits for a shared
// done/err response. Reports a terminal event when the switch ends.
// Assumes responses are single-cycle pulses and err_i wins over done_i.
module tsw_step_fsm
    import tsw_pkg::*;
#(
    parameter int N_STEPS = NUM_STEPS,
    parameter int CW      = CAUSE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [CW-1:0]      cause_i,
    input  logic               done_i,
    input  logic               err_i,
    output phase_e             phase_o,
    output logic [N_STEPS-1:0] req_o,
    output logic               accept_o,
    output logic               term_o,
    output logic               term_err_o
);
    phase_e phase_q, phase_d;
    logic   issued_q;
    logic   resp;

    assign accept_o   = start_i && (phase_q == PH_IDLE);
    assign resp       = (phase_q != PH_IDLE) && (done_i || err_i);
    assign term_o     = resp && (err_i || phase_q == PH_DESC);
    assign term_err_o = err_i;
    assign phase_o    = phase_q;

    // Next-phase selection from start, response and current step.
    always_comb begin
        phase_d = phase_q;
        if (accept_o) begin
            phase_d = (cause_i == CAUSE_IRET) ? PH_TREG : PH_BUSYF;
        end else if (resp) begin
            if (err_i) begin
                phase_d = PH_IDLE;
            end else begin
                unique case (phase_q)
                    PH_BUSYF: phase_d = PH_TREG;
                    PH_TREG:  phase_d = PH_STATE;
                    PH_STATE: phase_d = PH_DESC;
                    default:  phase_d = PH_IDLE;
                endcase
            end
        end
    end

    // Phase register and request-issued flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            issued_q <= 1'b0;
        end else begin
            phase_q  <= phase_d;
            issued_q <= (phase_d == phase_q) && (phase_q != PH_IDLE);
        end
    end

    // One request line per step, high in the first cycle of that step.
    for (genvar k = 0; k < N_STEPS; k++) begin : g_req
        assign req_o[k] = (phase_q == phase_e'(k + 1)) && !issued_q;
    end
endmodule

// File: rtl/tsw_outcome.sv
// Outcome resolver: classifies a terminal event by the step it occurred in
// and drives the registered rollback / corrupt / begin pulses and the held
// fault code. Assumes term_i never coincides with accept_i.
module tsw_outcome
    import tsw_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   accept_i,
    input  logic   term_i,
    input  logic   term_err_i,
    input  phase_e term_phase_i,
    output logic   begin_o,
    output logic   rollback_o,
    output logic   corrupt_o,
    output fault_e fault_o
);
    // Register outcome pulses and the fault code for the finished switch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            begin_o    <= 1'b0;
            rollback_o <= 1'b0;
            corrupt_o  <= 1'b0;
            fault_o    <= FLT_NONE;
        end else begin
            begin_o    <= 1'b0;
            rollback_o <= 1'b0;
            corrupt_o  <= 1'b0;
            if (accept_i) begin
                fault_o <= FLT_NONE;
            end
            if (term_i) begin
                unique case (term_phase_i)
                    PH_BUSYF, PH_TREG: begin
                        rollback_o <= 1'b1;
                        fault_o    <= FLT_ABORT;
                    end
                    PH_STATE: begin
                        corrupt_o <= 1'b1;
                        fault_o   <= FLT_CORRUPT;
                    end
                    PH_DESC: begin
                        begin_o <= 1'b1;
                        fault_o <= term_err_i ? FLT_POST : FLT_NONE;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tsw_priv_cap.sv
// Privilege capture: stores the code selector privilege field delivered
// with a successful state-restore response. Assumes the field is valid
// whenever done_i is high in the state-restore step.
module tsw_priv_cap
    import tsw_pkg::*;
#(
    parameter int W = RPL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  phase_e       phase_i,
    input  logic         done_i,
    input  logic         err_i,
    input  logic [W-1:0] rpl_i,
    output logic [W-1:0] cpl_o
);
    // Latch the new task's privilege level on state-restore completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpl_o <= '0;
        end else if (phase_i == PH_STATE && done_i && !err_i) begin
            cpl_o <= rpl_i;
        end
    end
endmodule

// File: rtl/tswitch_seq.sv
// Task switch control sequencer top: ties the step FSM, the outcome
// resolver and the privilege capture together. Commit is the descriptor
// step; busy is any non-idle phase. Assumes one agent response per step.
module tswitch_seq
    import tsw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic               done_i,
    input  logic               err_i,
    input  logic [RPL_W-1:0]   new_cs_rpl_i,
    output logic               busy_o,
    output logic               set_busy_req_o,
    output logic               treg_req_o,
    output logic               state_req_o,
    output logic               desc_req_o,
    output logic               commit_o,
    output logic               begin_o,
    output logic               rollback_o,
    output logic               corrupt_o,
    output logic [1:0]         fault_o,
    output logic [RPL_W-1:0]   new_cpl_o
);
    phase_e               phase;
    logic [NUM_STEPS-1:0] req;
    logic                 accept, term, term_err;
    fault_e               fault;

    tsw_step_fsm #(.N_STEPS(NUM_STEPS), .CW(CAUSE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cause_i    (cause_i),
        .done_i     (done_i),
        .err_i      (err_i),
        .phase_o    (phase),
        .req_o      (req),
        .accept_o   (accept),
        .term_o     (term),
        .term_err_o (term_err)
    );

    tsw_outcome u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept_i     (accept),
        .term_i       (term),
        .term_err_i   (term_err),
        .term_phase_i (phase),
        .begin_o      (begin_o),
        .rollback_o   (rollback_o),
        .corrupt_o    (corrupt_o),
        .fault_o      (fault)
    );

    tsw_priv_cap #(.W(RPL_W)) u_cpl (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_i (phase),
        .done_i  (done_i),
        .err_i   (err_i),
        .rpl_i   (new_cs_rpl_i),
        .cpl_o   (new_cpl_o)
    );

    assign busy_o         = (phase != PH_IDLE);
    assign commit_o       = (phase == PH_DESC);
    assign set_busy_req_o = req[0];
    assign treg_req_o     = req[1];
    assign state_req_o    = req[2];
    assign desc_req_o     = req[3];
    assign fault_o        = fault;
endmodule

// File: rtl/tswitch_seq_chk.sv
// Checker for tswitch_seq: per-cycle protocol and outcome properties.
module tswitch_seq_chk
    import tsw_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       busy_o,
    input logic       set_busy_req_o,
    input logic       treg_req_o,
    input logic       state_req_o,
    input logic       desc_req_o,
    input logic       commit_o,
    input logic       begin_o,
    input logic       rollback_o,
    input logic       corrupt_o,
    input logic [1:0] fault_o
);
    logic [3:0] reqs;
    assign reqs = {desc_req_o, state_req_o, treg_req_o, set_busy_req_o};

    // R3
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reqs));
    // R3
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reqs != 4'b0) |=> ((reqs & $past(reqs)) == 4'b0));
    // R3
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reqs != 4'b0) |-> busy_o);
    // R4
    rollback_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rollback_o |-> (fault_o == FLT_ABORT));
    // R5
    corrupt_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        corrupt_o |-> (fault_o == FLT_CORRUPT));
    // R7
    begin_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        begin_o |-> (fault_o == FLT_NONE || fault_o == FLT_POST));
    // R7
    outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({begin_o, rollback_o, corrupt_o}));
    // R6
    commit_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_busy_req_o || treg_req_o || state_req_o) |-> !commit_o);
    // R6
    desc_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_req_o |-> commit_o);
    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
    // R9
    outcome_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (begin_o || rollback_o || corrupt_o) |-> !busy_o);
    // R10
    fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (fault_o == FLT_NONE));
endmodule

bind tswitch_seq tswitch_seq_chk u_chk (.*);

// File: tb/tswitch_seq_bench.sv
// Scoreboard bench: the driver task queues the expected outcome of each
// switch; a monitor pops and compares on every outcome pulse.
module tswitch_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] cause_i = 3'd0;
    logic       done_i = 1'b0;
    logic       err_i = 1'b0;
    logic [1:0] new_cs_rpl_i = 2'd0;
    logic       busy_o, set_busy_req_o, treg_req_o, state_req_o, desc_req_o;
    logic       commit_o, begin_o, rollback_o, corrupt_o;
    logic [1:0] fault_o, new_cpl_o;

    typedef struct packed {
        logic [1:0] kind;   // 1 begin, 2 rollback, 3 corrupt
        logic [1:0] flt;
        logic [1:0] cpl;
    } exp_t;

    exp_t exp_q[$];
    int   vectors = 0;
    int   miscompares = 0;
    bit   finished = 1'b0;

    tswitch_seq u_tswitch_seq (.*);

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic logic [3:0] reqs();
        return {desc_req_o, state_req_o, treg_req_o, set_busy_req_o};
    endfunction

    // Monitor: pop and compare on every outcome pulse.
    always @(negedge clk) begin
        if (rst_n && (begin_o || rollback_o || corrupt_o)) begin
            logic [1:0] kind;
            kind = begin_o ? 2'd1 : (rollback_o ? 2'd2 : 2'd3);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7", kind, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(kind == e.kind, (e.kind == 2'd2) ? "R4" : (e.kind == 2'd3) ? "R5" : "R7",
                    kind, e.kind);
                chk(fault_o == e.flt, "R7", fault_o, e.flt);
                if (e.kind == 2'd1) chk(new_cpl_o == e.cpl, "R8", new_cpl_o, e.cpl);
            end
        end
    end

    // Serve one step: check its request, then respond one cycle later.
    task automatic serve_step(input int idx, input bit give_err, input logic [1:0] rpl,
                              input bit poke);
        logic [3:0] want;
        want = 4'b1 << idx;
        chk(reqs() == want, (idx == 0) ? "R2" : "R3", reqs(), want);
        chk(commit_o == (idx == 3), "R6", commit_o, idx == 3);
        chk(busy_o == 1'b1, "R9", busy_o, 1);
        @(negedge clk);
        chk(reqs() == 4'b0, "R3", reqs(), 0);
        if (give_err) err_i = 1'b1; else done_i = 1'b1;
        new_cs_rpl_i = rpl;
        if (poke) begin
            start_i = 1'b1;
            cause_i = 3'd4;
        end
        @(negedge clk);
        done_i  = 1'b0;
        err_i   = 1'b0;
        start_i = 1'b0;
    endtask

    // Driver: run one switch; fail_at = step index 0..3 or 4 for none.
    task automatic run_switch(input logic [2:0] cause, input int fail_at,
                              input logic [1:0] rpl, input bit poke);
        exp_t e;
        int   first;
        if (fail_at <= 1)      e = '{kind: 2'd2, flt: 2'b01, cpl: 2'd0};
        else if (fail_at == 2) e = '{kind: 2'd3, flt: 2'b10, cpl: 2'd0};
        else if (fail_at == 3) e = '{kind: 2'd1, flt: 2'b11, cpl: rpl};
        else                   e = '{kind: 2'd1, flt: 2'b00, cpl: rpl};
        exp_q.push_back(e);
        @(negedge clk);
        start_i = 1'b1;
        cause_i = cause;
        @(negedge clk);
        start_i = 1'b0;
        chk(fault_o == 2'b00, "R10", fault_o, 0);
        first = (cause == 3'd4) ? 1 : 0;
        for (int s = first; s < 4; s++) begin
            serve_step(s, s == fail_at, rpl, poke && s == 1);
            if (s == fail_at) break;
        end
        chk(reqs() == 4'b0, (fail_at == 2) ? "R5" : "R4", reqs(), 0);
        chk(busy_o == 1'b0, "R9", busy_o, 0);
        chk(commit_o == 1'b0, "R6", commit_o, 0);
        @(negedge clk);
        chk(reqs() == 4'b0, (fail_at == 3) ? "R7" : "R4", reqs(), 0);
        chk(fault_o == e.flt, "R10", fault_o, e.flt);
        chk(exp_q.size() == 0, "R7", exp_q.size(), 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        #400000;
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    // Main sequence.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(reqs() == 4'b0, "R1", reqs(), 0);
        chk(busy_o == 1'b0 && commit_o == 1'b0, "R1", {busy_o, commit_o}, 0);
        chk({begin_o, rollback_o, corrupt_o} == 3'b0, "R1",
            {begin_o, rollback_o, corrupt_o}, 0);
        chk(fault_o == 2'b00 && new_cpl_o == 2'b00, "R1", {fault_o, new_cpl_o}, 0);

        run_switch(3'd0, 4, 2'd3, 1'b0);  // call, clean
        run_switch(3'd1, 0, 2'd1, 1'b0);  // jump, error at busy-mark
        run_switch(3'd4, 4, 2'd1, 1'b1);  // return, clean, stray start ignored
        run_switch(3'd2, 1, 2'd2, 1'b0);  // interrupt, error at task register
        run_switch(3'd3, 2, 2'd0, 1'b0);  // exception, error in state restore
        repeat (3) @(negedge clk);
        chk(fault_o == 2'b10, "R10", fault_o, 2);
        chk(new_cpl_o == 2'd1, "R8", new_cpl_o, 1);
        run_switch(3'd0, 3, 2'd2, 1'b0);  // call, post-commit error
        run_switch(3'd4, 1, 2'd0, 1'b0);  // return, error at task register
        run_switch(3'd6, 4, 2'd0, 1'b0);  // unused cause code behaves as call
        run_switch(3'd1, 4, 2'd3, 1'b1);  // jump, clean, stray start ignored
        repeat (4) @(negedge clk);
        chk(busy_o == 1'b0, "R9", busy_o, 0);
        finish_run();
    end
endmodule